// File: doc/BRIEF.md
# Event-Driven Two-Cycle Control Processor

This block is a very small control-plane processor meant for fast event handling next to hardware. Its whole state is a bank of 256 general registers of 32 bits and a 128-entry special-register space. The special-register space holds the few internal registers the core needs: the current event's data and vector, an output-event port, the ALU's second operand and the condition flags. The remaining indices go out on a simple read/write bus to the peripherals around it. Instructions are 18 bits wide and come from an external program memory with a one-cycle read. There are four operations: load a small immediate into a special register, copy between the two register spaces, a read-modify-write ALU operation on a general register, and a conditional absolute branch.

Every instruction takes a fetch cycle and an execute cycle. There is no visible pipeline: whatever one instruction writes, the next one reads. Event handling goes through the branch. A taken branch whose target is address 0 does not go to address 0. It takes the vector at the head of the input event queue, pops that entry, and captures the entry's data and vector into special registers. If the queue is empty, the core waits on that branch. Writing the output-event port pushes a word to the output queue. While that queue is full, the core waits on the writing instruction.

Top module: `evt_ctrl_cpu`

## Requirements
- R1: During and after reset the program address is the reset vector (default 1), and out_push, evt_pop and spr_we are low. The opcode sits in bits [17:16]: 00 POKE, 01 COPY, 10 MODIFY, 11 BRANCH.
- R2: Each instruction spends one fetch cycle and one execute cycle, so without stalls imem_addr holds each value for exactly two cycles. A register written by one instruction reads back its new value in the next instruction.
- R3: POKE writes the 9-bit immediate in bits [8:0], sign-extended to 32 bits, into the special register indexed by bits [15:9].
- R4: COPY takes its direction from bit 15 (0: general to special, 1: special to general), the general index from bits [14:7] and the special index from bits [6:0].
- R5: MODIFY replaces the general register indexed by bits [15:8] with f(reg, B), where B is special register 3 and f comes from bits [3:0]. The codes are: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 left shift by B[4:0], 6 logical right shift by B[4:0], 7 move B, 8 increment, and any other code leaves the register unchanged.
- R6: MODIFY sets the flags Z (result zero), N (result bit 31) and C (carry out for add and increment, unsigned borrow for subtract, 0 otherwise). Special register 4 reads the flags as bits 0=Z, 1=N, 2=C, and writing that register sets them.
- R7: BRANCH takes the condition from bits [15:13] (0 always, 1 Z, 2 not Z, 3 N, 4 not N, 5 C, 6 not C, 7 event queue not empty) and the absolute target from bits [12:0]. When the condition is false, execution continues at the next address.
- R8: A taken BRANCH to target 0 with a queued event pops that event in its execute cycle and continues at the event vector. In the same cycle it loads special register 0 with the event data and special register 1 with the vector.
- R9: A taken BRANCH to target 0 with the event queue empty holds the program address and pops nothing until an event arrives.
- R10: Writing special register 2 by POKE or COPY pushes the written word to the output queue. While out_full is high, no push happens and the program address holds. The push occurs once space is free.
- R11: Special indices 8 to 127 are external: writes pulse spr_we with spr_addr and spr_wdata, and reads return spr_rdata. Reads of indices 2 and 5 to 7 return 0. Writes to indices 0, 1 and 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 13 | Program memory address (the program counter) |
| imem_rdata | input | 18 | Instruction word, registered one cycle after imem_addr |
| evt_valid | input | 1 | Input event queue holds an entry |
| evt_vector | input | 13 | Vector of the head event |
| evt_data | input | 32 | Data of the head event |
| evt_pop | output | 1 | Removes the head event |
| out_full | input | 1 | Output event queue is full |
| out_push | output | 1 | Pushes out_data into the output queue |
| out_data | output | 32 | Word pushed to the output queue |
| spr_we | output | 1 | Write strobe for an external special register |
| spr_addr | output | 7 | Special-register index of the executing instruction |
| spr_wdata | output | 32 | Write data for an external special register |
| spr_rdata | input | 32 | Read data from the external special register at spr_addr |

## Verification
The assertions assume the program memory acts as a one-cycle registered read of imem_addr. They also assume evt_vector and evt_data stay steady while evt_valid is high and no pop has happened, and that out_full changes only between clock edges. The bench keeps to these assumptions by modelling the program store as a registered array and the event queue as a small array that advances only on evt_pop. It drives out_full only at falling edges. Every program it runs is built from the encodings in the requirements, so no undefined opcode ever reaches the core.

// File: rtl/evt_cpu_pkg.sv
package evt_cpu_pkg;

    localparam int DATA_W   = 32;
    localparam int INSN_W   = 18;
    localparam int PC_W     = 13;
    localparam int GPR_N    = 256;
    localparam int SPR_N    = 128;
    localparam int GPR_AW   = $clog2(GPR_N);
    localparam int SPR_AW   = $clog2(SPR_N);
    localparam int IMM_W    = 9;
    localparam int ALU_OP_W = 4;
    localparam int COND_W   = 3;
    localparam int SHAMT_W  = $clog2(DATA_W);

    localparam logic [SPR_AW-1:0] SPR_EVT_DATA = 7'd0;
    localparam logic [SPR_AW-1:0] SPR_EVT_VEC  = 7'd1;
    localparam logic [SPR_AW-1:0] SPR_OUT_PORT = 7'd2;
    localparam logic [SPR_AW-1:0] SPR_ALU_B    = 7'd3;
    localparam logic [SPR_AW-1:0] SPR_FLAGS    = 7'd4;
    localparam logic [SPR_AW-1:0] SPR_EXT_BASE = 7'd8;

    typedef enum logic [1:0] {
        OP_POKE   = 2'b00,
        OP_COPY   = 2'b01,
        OP_MODIFY = 2'b10,
        OP_BRANCH = 2'b11
    } opcode_e;

    typedef enum logic [ALU_OP_W-1:0] {
        ALU_ADD = 4'd0,
        ALU_SUB = 4'd1,
        ALU_AND = 4'd2,
        ALU_OR  = 4'd3,
        ALU_XOR = 4'd4,
        ALU_SHL = 4'd5,
        ALU_SHR = 4'd6,
        ALU_MOV = 4'd7,
        ALU_INC = 4'd8
    } alu_op_e;

    typedef enum logic [COND_W-1:0] {
        CC_ALWAYS = 3'd0,
        CC_Z      = 3'd1,
        CC_NZ     = 3'd2,
        CC_N      = 3'd3,
        CC_NN     = 3'd4,
        CC_C      = 3'd5,
        CC_NC     = 3'd6,
        CC_EVT    = 3'd7
    } cond_e;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef struct packed {
        logic c;
        logic n;
        logic z;
    } flags_t;

    typedef struct packed {
        opcode_e             op;
        logic [SPR_AW-1:0]   spr;
        logic [GPR_AW-1:0]   gpr;
        logic                to_gpr;
        logic [DATA_W-1:0]   imm;
        alu_op_e             alu;
        cond_e               cond;
        logic [PC_W-1:0]     target;
    } insn_t;

    function automatic logic [DATA_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/evt_cpu_decode.sv
module evt_cpu_decode
    import evt_cpu_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output insn_t             dec
);
    opcode_e op;

    always_comb begin
        op         = opcode_e'(insn[17:16]);
        dec        = '0;
        dec.op     = op;
        dec.imm    = sext_imm(insn[IMM_W-1:0]);
        dec.alu    = alu_op_e'(insn[ALU_OP_W-1:0]);
        dec.cond   = cond_e'(insn[15:13]);
        dec.target = insn[PC_W-1:0];
        dec.to_gpr = 1'b0;
        unique case (op)
            OP_POKE: begin
                dec.spr = insn[15:9];
                dec.gpr = '0;
            end
            OP_COPY: begin
                dec.to_gpr = insn[15];
                dec.gpr    = insn[14:7];
                dec.spr    = insn[6:0];
            end
            OP_MODIFY: begin
                dec.gpr = insn[15:8];
                dec.spr = SPR_ALU_B;
            end
            default: begin
                dec.gpr = '0;
                dec.spr = '0;
            end
        endcase
    end
endmodule

// File: rtl/evt_cpu_alu.sv
module evt_cpu_alu
    import evt_cpu_pkg::*;
(
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output flags_t            flg
);
    logic [DATA_W:0] wide;
    logic            carry;

    always_comb begin
        wide  = '0;
        carry = 1'b0;
        res   = a;
        case (op)
            ALU_ADD: begin
                wide  = {1'b0, a} + {1'b0, b};
                res   = wide[DATA_W-1:0];
                carry = wide[DATA_W];
            end
            ALU_SUB: begin
                wide  = {1'b0, a} - {1'b0, b};
                res   = wide[DATA_W-1:0];
                carry = wide[DATA_W];
            end
            ALU_AND: res = a & b;
            ALU_OR:  res = a | b;
            ALU_XOR: res = a ^ b;
            ALU_SHL: res = a << b[SHAMT_W-1:0];
            ALU_SHR: res = a >> b[SHAMT_W-1:0];
            ALU_MOV: res = b;
            ALU_INC: begin
                wide  = {1'b0, a} + {{DATA_W{1'b0}}, 1'b1};
                res   = wide[DATA_W-1:0];
                carry = wide[DATA_W];
            end
            default: res = a;
        endcase
        flg.z = (res == '0);
        flg.n = res[DATA_W-1];
        flg.c = carry;
    end
endmodule

// File: rtl/evt_cpu_gpr.sv
module evt_cpu_gpr
    import evt_cpu_pkg::*;
#(
    parameter int DEPTH = GPR_N,
    parameter int WIDTH = DATA_W
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/evt_ctrl_cpu.sv
module evt_ctrl_cpu
    import evt_cpu_pkg::*;
#(
    parameter logic [PC_W-1:0] RESET_PC = 13'd1
) (
    input  logic              clk,
    input  logic              rst,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [INSN_W-1:0] imem_rdata,
    input  logic              evt_valid,
    input  logic [PC_W-1:0]   evt_vector,
    input  logic [DATA_W-1:0] evt_data,
    output logic              evt_pop,
    input  logic              out_full,
    output logic              out_push,
    output logic [DATA_W-1:0] out_data,
    output logic              spr_we,
    output logic [SPR_AW-1:0] spr_addr,
    output logic [DATA_W-1:0] spr_wdata,
    input  logic [DATA_W-1:0] spr_rdata
);
    phase_e            phase_q;
    logic [PC_W-1:0]   pc_q;
    logic [DATA_W-1:0] evt_data_q;
    logic [PC_W-1:0]   evt_vec_q;
    logic [DATA_W-1:0] alu_b_q;
    flags_t            flags_q;

    insn_t             dec;
    logic [DATA_W-1:0] gpr_rd;
    logic [DATA_W-1:0] spr_rd;
    logic [DATA_W-1:0] alu_res;
    flags_t            alu_flg;

    logic              exec;
    logic              spr_wr;
    logic [DATA_W-1:0] wr_val;
    logic              to_port;
    logic              cond_ok;
    logic              br_taken;
    logic              dispatch;
    logic              disp_wait;
    logic              stall;
    logic              advance;
    logic              gpr_we;
    logic [DATA_W-1:0] gpr_wd;
    logic [PC_W-1:0]   pc_next;

    evt_cpu_decode u_dec (
        .insn (imem_rdata),
        .dec  (dec)
    );

    evt_cpu_alu u_alu (
        .op  (dec.alu),
        .a   (gpr_rd),
        .b   (alu_b_q),
        .res (alu_res),
        .flg (alu_flg)
    );

    evt_cpu_gpr #(.DEPTH(GPR_N), .WIDTH(DATA_W)) u_gpr (
        .clk   (clk),
        .we    (gpr_we),
        .waddr (dec.gpr),
        .wdata (gpr_wd),
        .raddr (dec.gpr),
        .rdata (gpr_rd)
    );

    // special-register read mux: internal low indices, external above the base
    always_comb begin
        spr_rd = '0;
        if (dec.spr >= SPR_EXT_BASE) begin
            spr_rd = spr_rdata;
        end else begin
            case (dec.spr)
                SPR_EVT_DATA: spr_rd = evt_data_q;
                SPR_EVT_VEC:  spr_rd = {{(DATA_W-PC_W){1'b0}}, evt_vec_q};
                SPR_ALU_B:    spr_rd = alu_b_q;
                SPR_FLAGS:    spr_rd = {{(DATA_W-3){1'b0}}, flags_q};
                default:      spr_rd = '0;
            endcase
        end
    end

    always_comb begin
        case (dec.cond)
            CC_ALWAYS: cond_ok = 1'b1;
            CC_Z:      cond_ok = flags_q.z;
            CC_NZ:     cond_ok = !flags_q.z;
            CC_N:      cond_ok = flags_q.n;
            CC_NN:     cond_ok = !flags_q.n;
            CC_C:      cond_ok = flags_q.c;
            CC_NC:     cond_ok = !flags_q.c;
            CC_EVT:    cond_ok = evt_valid;
            default:   cond_ok = 1'b0;
        endcase
    end

    assign exec      = (phase_q == PH_EXEC);
    assign spr_wr    = exec && ((dec.op == OP_POKE) || (dec.op == OP_COPY && !dec.to_gpr));
    assign wr_val    = (dec.op == OP_POKE) ? dec.imm : gpr_rd;
    assign to_port   = spr_wr && (dec.spr == SPR_OUT_PORT);
    assign br_taken  = exec && (dec.op == OP_BRANCH) && cond_ok;
    assign dispatch  = br_taken && (dec.target == '0);
    assign disp_wait = dispatch && !evt_valid;
    assign stall     = (to_port && out_full) || disp_wait;
    assign advance   = exec && !stall;

    assign evt_pop   = dispatch && evt_valid;
    assign out_push  = to_port && !out_full;
    assign out_data  = wr_val;
    assign spr_we    = spr_wr && (dec.spr >= SPR_EXT_BASE);
    assign spr_addr  = dec.spr;
    assign spr_wdata = wr_val;

    assign gpr_we = advance && ((dec.op == OP_MODIFY) || (dec.op == OP_COPY && dec.to_gpr));
    assign gpr_wd = (dec.op == OP_MODIFY) ? alu_res : spr_rd;

    always_comb begin
        if (dispatch)      pc_next = evt_vector;
        else if (br_taken) pc_next = dec.target;
        else               pc_next = pc_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_FETCH;
            pc_q       <= RESET_PC;
            evt_data_q <= '0;
            evt_vec_q  <= '0;
            alu_b_q    <= '0;
            flags_q    <= '0;
        end else begin
            if (!exec) begin
                phase_q <= PH_EXEC;
            end else if (advance) begin
                phase_q <= PH_FETCH;
                pc_q    <= pc_next;
            end
            if (evt_pop) begin
                evt_data_q <= evt_data;
                evt_vec_q  <= evt_vector;
            end
            if (advance && dec.op == OP_MODIFY) begin
                flags_q <= alu_flg;
            end else if (advance && spr_wr && dec.spr == SPR_FLAGS) begin
                flags_q <= flags_t'(wr_val[2:0]);
            end
            if (advance && spr_wr && dec.spr == SPR_ALU_B) begin
                alu_b_q <= wr_val;
            end
        end
    end

    assign imem_addr = pc_q;

    // R2: a fetch cycle is always followed by an execute cycle
    a_r2_fetch_then_exec: assert property (@(posedge clk) disable iff (rst)
        phase_q == PH_FETCH |=> phase_q == PH_EXEC);

    // R2: the program address only moves at the end of an execute cycle
    a_r2_pc_moves_after_exec: assert property (@(posedge clk) disable iff (rst)
        !$stable(imem_addr) |-> $past(phase_q) == PH_EXEC);

    // R10: nothing is pushed into a full output queue
    a_r10_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        out_push |-> !out_full);

    // R10: a blocked port write keeps the program address
    a_r10_stall_holds_pc: assert property (@(posedge clk) disable iff (rst)
        (to_port && out_full) |=> $stable(imem_addr));

    // R8: a pop is only issued on a queued entry
    a_r8_pop_needs_valid: assert property (@(posedge clk) disable iff (rst)
        evt_pop |-> evt_valid);

    // R8: after a pop execution continues at the popped vector
    a_r8_pop_loads_vector: assert property (@(posedge clk) disable iff (rst)
        evt_pop |=> imem_addr == $past(evt_vector));

    // R9: waiting on an empty queue holds the address and stays in execute
    a_r9_empty_hold: assert property (@(posedge clk) disable iff (rst)
        disp_wait |=> (phase_q == PH_EXEC && $stable(imem_addr)));
endmodule

// File: tb/evt_ctrl_cpu_bench.sv
module evt_ctrl_cpu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] imem_addr;
    logic [17:0] imem_rdata;
    logic        evt_valid;
    logic [12:0] evt_vector;
    logic [31:0] evt_data;
    logic        evt_pop;
    logic        out_full = 1'b0;
    logic        out_push;
    logic [31:0] out_data;
    logic        spr_we;
    logic [6:0]  spr_addr;
    logic [31:0] spr_wdata;
    logic [31:0] spr_rdata;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    logic [17:0] rom [256];
    logic [31:0] push_log [16];
    int          push_cnt = 0;
    logic [6:0]  sw_idx [8];
    logic [31:0] sw_dat [8];
    int          sw_cnt = 0;
    int          pop_cnt = 0;

    logic [12:0] evq_vec [4];
    logic [31:0] evq_dat [4];
    int          ev_head = 0;
    int          ev_tail = 0;

    always #10 clk = ~clk;

    evt_ctrl_cpu u_evt_ctrl_cpu (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .evt_valid(evt_valid), .evt_vector(evt_vector), .evt_data(evt_data), .evt_pop(evt_pop),
        .out_full(out_full), .out_push(out_push), .out_data(out_data),
        .spr_we(spr_we), .spr_addr(spr_addr), .spr_wdata(spr_wdata), .spr_rdata(spr_rdata)
    );

    always @(posedge clk) imem_rdata <= rom[imem_addr[7:0]];

    assign spr_rdata  = 32'hC0DE0000 | {25'b0, spr_addr};
    assign evt_valid  = (ev_head != ev_tail);
    assign evt_vector = evq_vec[ev_head[1:0]];
    assign evt_data   = evq_dat[ev_head[1:0]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && evt_pop) ev_head <= ev_head + 1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (out_push && push_cnt < 16) begin
                push_log[push_cnt] = out_data;
                push_cnt++;
            end
            if (spr_we && sw_cnt < 8) begin
                sw_idx[sw_cnt] = spr_addr;
                sw_dat[sw_cnt] = spr_wdata;
                sw_cnt++;
            end
            if (evt_pop) pop_cnt++;
        end
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [17:0] enc_poke(input logic [6:0] s, input logic [8:0] imm);
        return {2'b00, s, imm};
    endfunction
    function automatic logic [17:0] enc_copy(input logic dir, input logic [7:0] g, input logic [6:0] s);
        return {2'b01, dir, g, s};
    endfunction
    function automatic logic [17:0] enc_mod(input logic [7:0] g, input logic [3:0] op);
        return {2'b10, g, 4'b0000, op};
    endfunction
    function automatic logic [17:0] enc_br(input logic [2:0] cc, input logic [12:0] t);
        return {2'b11, cc, t};
    endfunction

    // returns {C, N, Z, result} from the arithmetic in R5 and R6
    function automatic logic [34:0] alu_model(input int op, input logic [31:0] a, input logic [31:0] b);
        logic [32:0] w;
        logic [31:0] r;
        logic        c;
        c = 1'b0;
        case (op)
            0: begin w = {1'b0, a} + {1'b0, b}; r = w[31:0]; c = w[32]; end
            1: begin r = a - b; c = (a < b); end
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            5: r = a << b[4:0];
            6: r = a >> b[4:0];
            7: r = b;
            8: begin w = {1'b0, a} + 33'd1; r = w[31:0]; c = w[32]; end
            default: r = a;
        endcase
        return {c, r[31], (r == 32'd0), r};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 256; i++) rom[i] = enc_br(3'd0, 13'(i));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        push_cnt = 0;
        sw_cnt = 0;
        pop_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_pushes(input int n, input int limit);
        for (int i = 0; i < limit && push_cnt < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    logic [8:0] pa [6];
    logic [8:0] pb [6];

    initial begin
        pa[0] = 9'd5;   pb[0] = 9'd3;
        pa[1] = 9'd3;   pb[1] = 9'd5;
        pa[2] = 9'h1FF; pb[2] = 9'd1;
        pa[3] = 9'd0;   pb[3] = 9'd0;
        pa[4] = 9'h0FF; pb[4] = 9'h100;
        pa[5] = 9'h1F9; pb[5] = 9'd2;

        // ---- test A: reset, sequencing, branch, ignored and external registers
        clear_rom();
        rom[1]  = enc_poke(7'd4, 9'h001);
        rom[2]  = enc_br(3'd2, 13'd5);
        rom[3]  = enc_poke(7'd2, 9'h011);
        rom[4]  = enc_br(3'd1, 13'd6);
        rom[5]  = enc_poke(7'd2, 9'h0EE);
        rom[6]  = enc_poke(7'd0, 9'h007);
        rom[7]  = enc_copy(1'b1, 8'd1, 7'd0);
        rom[8]  = enc_copy(1'b0, 8'd1, 7'd2);
        rom[9]  = enc_poke(7'd10, 9'h1FD);
        rom[10] = enc_copy(1'b1, 8'd2, 7'd11);
        rom[11] = enc_copy(1'b0, 8'd2, 7'd2);
        rom[12] = enc_copy(1'b1, 8'd3, 7'd6);
        rom[13] = enc_copy(1'b0, 8'd3, 7'd2);
        rom[14] = enc_br(3'd0, 13'd14);
        @(negedge clk);
        check("R1 reset address", 32'(imem_addr), 32'd1);
        check("R1 reset strobes", {29'b0, out_push, evt_pop, spr_we}, 32'd0);
        do_reset();
        check("R1 address after reset", 32'(imem_addr), 32'd1);
        for (int k = 0; k < 6; k++) begin
            check("R2 two cycles per instruction", 32'(imem_addr), 32'(1 + k / 2));
            @(negedge clk);
        end
        wait_pushes(4, 200);
        check("R7 push count (untaken and taken branch)", 32'(push_cnt), 32'd4);
        check("R3 R7 first push", push_log[0], 32'h11);
        check("R11 write to event data ignored", push_log[1], 32'h0);
        check("R11 external read", push_log[2], 32'hC0DE000B);
        check("R11 unused index reads zero", push_log[3], 32'h0);
        check("R11 external write count", 32'(sw_cnt), 32'd1);
        check("R11 external write index", 32'(sw_idx[0]), 32'd10);
        check("R3 sign-extended immediate", sw_dat[0], 32'hFFFFFFFD);

        // ---- test B: ALU sweep (R2 R4 R5 R6)
        clear_rom();
        for (int op = 0; op < 11; op++) begin
            for (int p = 0; p < 6; p++) begin
                logic [31:0] a, b;
                logic [34:0] m;
                a = {{23{pa[p][8]}}, pa[p]};
                b = {{23{pb[p][8]}}, pb[p]};
                m = alu_model(op, a, b);
                rom[1] = enc_poke(7'd3, pa[p]);
                rom[2] = enc_copy(1'b1, 8'h37, 7'd3);
                rom[3] = enc_poke(7'd3, pb[p]);
                rom[4] = enc_mod(8'h37, 4'(op));
                rom[5] = enc_copy(1'b0, 8'h37, 7'd2);
                rom[6] = enc_copy(1'b1, 8'hC8, 7'd4);
                rom[7] = enc_copy(1'b0, 8'hC8, 7'd2);
                rom[8] = enc_br(3'd0, 13'd8);
                do_reset();
                wait_pushes(2, 60);
                check($sformatf("R5 result op=%0d pair=%0d", op, p), push_log[0], m[31:0]);
                check($sformatf("R6 flags op=%0d pair=%0d", op, p), push_log[1], {29'b0, m[34:32]});
            end
        end

        // ---- test C: output queue full (R10)
        clear_rom();
        rom[1] = enc_poke(7'd2, 9'h055);
        rom[2] = enc_poke(7'd2, 9'h066);
        rom[3] = enc_br(3'd0, 13'd3);
        out_full = 1'b1;
        do_reset();
        repeat (20) @(negedge clk);
        check("R10 no push while full", 32'(push_cnt), 32'd0);
        check("R10 address held while full", 32'(imem_addr), 32'd1);
        out_full = 1'b0;
        wait_pushes(2, 40);
        repeat (6) @(negedge clk);
        check("R10 pushes after release", 32'(push_cnt), 32'd2);
        check("R10 first word", push_log[0], 32'h55);
        check("R10 second word", push_log[1], 32'h66);

        // ---- test D: event dispatch (R8 R9)
        clear_rom();
        rom[1]  = enc_br(3'd0, 13'd0);
        rom[20] = enc_copy(1'b1, 8'd5, 7'd0);
        rom[21] = enc_copy(1'b0, 8'd5, 7'd2);
        rom[22] = enc_copy(1'b1, 8'd6, 7'd1);
        rom[23] = enc_copy(1'b0, 8'd6, 7'd2);
        rom[24] = enc_br(3'd0, 13'd0);
        do_reset();
        repeat (20) @(negedge clk);
        check("R9 address held on empty queue", 32'(imem_addr), 32'd1);
        check("R9 no pop on empty queue", 32'(pop_cnt), 32'd0);
        evq_vec[0] = 13'd20; evq_dat[0] = 32'hABCD1234;
        evq_vec[1] = 13'd20; evq_dat[1] = 32'h00001357;
        ev_tail = ev_head + 2;
        wait_pushes(4, 100);
        repeat (10) @(negedge clk);
        check("R8 pop count", 32'(pop_cnt), 32'd2);
        check("R8 first event data", push_log[0], 32'hABCD1234);
        check("R8 first event vector", push_log[1], 32'd20);
        check("R8 second event data", push_log[2], 32'h00001357);
        check("R8 second event vector", push_log[3], 32'd20);
        check("R9 waits again when drained", 32'(imem_addr), 32'd24);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule